// File: doc/BRIEF.md
# Tagged Circular Register Stack

This block stores eight 64-bit operand registers arranged as a circular stack. A 3-bit top pointer marks the current stack top, and a stack-relative index i reaches register slot ST(i). Each physical slot carries a one-bit occupancy tag. Every command is checked against the tags. A command that would read a vacant slot raises an empty fault. A command that would overwrite a held slot raises a full fault. When a command faults, none of its effects are applied.

A single synchronous command port drives the block. The port carries an operation code, a stack-relative index, a 64-bit data word and two exemption qualifiers. The first qualifier lets a classify-style read look at any slot without the vacancy check. The second lets a copy from the stack top land on an occupied slot without the occupancy check. A separate 4-bit condition-code field lives beside the stack and is presented as a 16-bit status word. The block performs no arithmetic. It only stores, addresses and checks values.

Top module: `regstk_top`

## Requirements
- R1: After reset the top pointer is 0, all eight tags are vacant (0), both fault outputs and rd_valid are low, and the status word is 0.
- R2: Operation code 1 (push) first moves the top pointer to (top - 1) mod 8 and then writes cmd_data into that slot and marks its tag occupied. If that slot is already occupied, a full fault is raised instead.
- R3: Operation code 2 (pop) returns the slot at the current top on rd_data with rd_valid high, clears that slot's tag, and then moves the top pointer to (top + 1) mod 8. If that slot is vacant, an empty fault is raised instead.
- R4: Operation codes 3, 4 and 5 address physical slot (top + cmd_idx) mod 8.
- R5: Operation code 3 (read) returns the addressed slot. It raises an empty fault if the slot is vacant, unless cmd_rd_any is high, in which case the stored contents are returned without a fault.
- R6: Operation code 4 (write) stores cmd_data into the addressed slot and marks it occupied. It raises a full fault if the slot is occupied, unless cmd_wr_over is high.
- R7: Operation code 5 (modify) returns the old contents of the addressed slot and stores cmd_data in it. It raises an empty fault if the slot is vacant. No qualifier exempts it.
- R8: A faulting command leaves registers, tags, top pointer and rd_data unchanged, keeps rd_valid low, and pulses its fault output for exactly that one cycle.
- R9: Operation code 6 loads cmd_data[3:0] as {C3,C2,C1,C0}. The status word then shows C3, C2, C1 and C0 at bits 14, 10, 9 and 8, with every other bit 0. The stack is unaffected. Codes 0 and 7 do nothing.
- R10: cmd_rd_any has no effect on any operation except read, and cmd_wr_over has no effect on any operation except write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Operation code |
| cmd_idx | input | 3 | Stack-relative index i |
| cmd_data | input | 64 | Write data / condition-code nibble |
| cmd_rd_any | input | 1 | Exempt a read from the vacancy check |
| cmd_wr_over | input | 1 | Exempt a write from the occupancy check |
| rd_data | output | 64 | Data returned by pop, read or modify |
| rd_valid | output | 1 | rd_data was refreshed by the last command |
| flt_empty | output | 1 | Empty-register fault pulse |
| flt_full | output | 1 | Full-register fault pulse |
| top_ptr | output | 3 | Current top pointer |
| tag_vec | output | 8 | Occupancy tag per physical slot |
| cc_word | output | 16 | Status word carrying the condition codes |

## Verification
Every result is registered. A command presented before a rising edge therefore shows its read data, fault pulses, new top pointer, tags and status word during the cycle that follows that edge, and each command's result holds for exactly one cycle before the next command's result replaces it. The bench drives each command on a falling edge and compares all outputs against its own model on the next falling edge. Each comparison falls in the single cycle in which that command's result is shown, before the next command takes effect. Back-to-back commands therefore also check that a fault pulse lasts one cycle and that state changes appear only at the accepting edge.

// File: rtl/regstk_pkg.sv
package regstk_pkg;

    localparam int OP_W = 3;
    localparam int CC_W = 4;
    localparam int SW_W = 16;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 3'd0,
        OP_PUSH   = 3'd1,
        OP_POP    = 3'd2,
        OP_READ   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_MODIFY = 3'd5,
        OP_SETCC  = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    // status-word bit position of condition code n (n = 0..3)
    function automatic int cc_pos(input int n);
        case (n)
            0:       return 8;
            1:       return 9;
            2:       return 10;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/regstk_addr.sv
module regstk_addr #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] top,
    input  logic [IDX_W-1:0] rel_idx,
    output logic [IDX_W-1:0] sel_slot,
    output logic [IDX_W-1:0] below_top,
    output logic [IDX_W-1:0] above_top
);

    // truncation to IDX_W gives the wrap-around modulo the depth
    always_comb begin
        sel_slot  = IDX_W'(top + rel_idx);
        below_top = IDX_W'(top - 1'b1);
        above_top = IDX_W'(top + 1'b1);
    end

endmodule

// File: rtl/regstk_guard.sv
module regstk_guard
    import regstk_pkg::*;
(
    input  op_e  op,
    input  logic tag_top,
    input  logic tag_sel,
    input  logic tag_below,
    input  logic rd_any,
    input  logic wr_over,
    output logic empty_flt,
    output logic full_flt
);

    always_comb begin
        empty_flt = 1'b0;
        full_flt  = 1'b0;
        unique case (op)
            OP_PUSH:   full_flt  = tag_below;
            OP_POP:    empty_flt = !tag_top;
            OP_READ:   empty_flt = !tag_sel && !rd_any;
            OP_WRITE:  full_flt  = tag_sel && !wr_over;
            OP_MODIFY: empty_flt = !tag_sel;
            default: begin
                empty_flt = 1'b0;
                full_flt  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/regstk_ccfield.sv
module regstk_ccfield
    import regstk_pkg::*;
(
    input  logic [CC_W-1:0] cc,
    output logic [SW_W-1:0] word
);

    logic [SW_W-1:0] placed [CC_W+1];

    assign placed[0] = '0;

    for (genvar n = 0; n < CC_W; n++) begin : g_place
        always_comb begin
            placed[n+1] = placed[n];
            placed[n+1][cc_pos(n)] = cc[n];
        end
    end

    assign word = placed[CC_W];

endmodule

// File: rtl/regstk_top.sv
module regstk_top
    import regstk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [OP_W-1:0]            cmd_op,
    input  logic [$clog2(DEPTH)-1:0]   cmd_idx,
    input  logic [DATA_W-1:0]          cmd_data,
    input  logic                       cmd_rd_any,
    input  logic                       cmd_wr_over,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic                       flt_empty,
    output logic                       flt_full,
    output logic [$clog2(DEPTH)-1:0]   top_ptr,
    output logic [DEPTH-1:0]           tag_vec,
    output logic [SW_W-1:0]            cc_word
);

    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] regs;
        logic [DEPTH-1:0]             tags;
        logic [IDX_W-1:0]             top;
        logic [CC_W-1:0]              cc;
        logic [DATA_W-1:0]            rd;
        logic                         rd_vld;
        logic                         f_empty;
        logic                         f_full;
    } state_t;

    state_t st_d, st_q;

    op_e              op;
    logic [IDX_W-1:0] sel_slot, below_top, above_top;
    logic             empty_flt, full_flt;

    assign op = op_e'(cmd_op);

    regstk_addr #(.IDX_W(IDX_W)) addr_i (
        .top       (st_q.top),
        .rel_idx   (cmd_idx),
        .sel_slot  (sel_slot),
        .below_top (below_top),
        .above_top (above_top)
    );

    regstk_guard guard_i (
        .op        (op),
        .tag_top   (st_q.tags[st_q.top]),
        .tag_sel   (st_q.tags[sel_slot]),
        .tag_below (st_q.tags[below_top]),
        .rd_any    (cmd_rd_any),
        .wr_over   (cmd_wr_over),
        .empty_flt (empty_flt),
        .full_flt  (full_flt)
    );

    regstk_ccfield cc_i (
        .cc   (st_q.cc),
        .word (cc_word)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rd_vld  = 1'b0;
        st_d.f_empty = empty_flt;
        st_d.f_full  = full_flt;
        if (!empty_flt && !full_flt) begin
            unique case (op)
                OP_PUSH: begin
                    st_d.top             = below_top;
                    st_d.regs[below_top] = cmd_data;
                    st_d.tags[below_top] = 1'b1;
                end
                OP_POP: begin
                    st_d.rd              = st_q.regs[st_q.top];
                    st_d.rd_vld          = 1'b1;
                    st_d.tags[st_q.top]  = 1'b0;
                    st_d.top             = above_top;
                end
                OP_READ: begin
                    st_d.rd     = st_q.regs[sel_slot];
                    st_d.rd_vld = 1'b1;
                end
                OP_WRITE: begin
                    st_d.regs[sel_slot] = cmd_data;
                    st_d.tags[sel_slot] = 1'b1;
                end
                OP_MODIFY: begin
                    st_d.rd             = st_q.regs[sel_slot];
                    st_d.rd_vld         = 1'b1;
                    st_d.regs[sel_slot] = cmd_data;
                end
                OP_SETCC: st_d.cc = cmd_data[CC_W-1:0];
                default:  st_d.cc = st_q.cc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rd;
    assign rd_valid  = st_q.rd_vld;
    assign flt_empty = st_q.f_empty;
    assign flt_full  = st_q.f_full;
    assign top_ptr   = st_q.top;
    assign tag_vec   = st_q.tags;

    // R2: push lowers the top pointer by one unless it faults
    a_r2_push_moves_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_PUSH) |=> (flt_full || top_ptr == IDX_W'($past(top_ptr) - 1'b1)));

    // R3: popping a vacant top always faults
    a_r3_pop_vacant: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_POP && !tag_vec[top_ptr]) |=> flt_empty);

    // R6: a successful write leaves the addressed slot occupied
    a_r6_write_tags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_WRITE) |=> (flt_full || tag_vec[$past(sel_slot)]));

    // R8: a fault freezes pointer, tags and returned data
    a_r8_fault_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_empty || flt_full) |-> ($stable(top_ptr) && $stable(tag_vec)
                                     && $stable(rd_data) && !rd_valid));

    // R9: condition-code load lands at its status-word positions
    a_r9_cc_place: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_SETCC) |=> (cc_word[14] == $past(cmd_data[3])
                                  && cc_word[8] == $past(cmd_data[0])));

    // R10: the read exemption never spares a pop
    a_r10_pop_no_exempt: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_POP && cmd_rd_any && !tag_vec[top_ptr]) |=> flt_empty);

endmodule

// File: tb/regstk_top_tb_top.sv
module regstk_top_tb_top;

    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [2:0]    cmd_idx = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          cmd_rd_any = 1'b0;
    logic          cmd_wr_over = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, flt_empty, flt_full;
    logic [2:0]    top_ptr;
    logic [7:0]    tag_vec;
    logic [15:0]   cc_word;

    always #10 clk = ~clk;

    regstk_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_data(cmd_data), .cmd_rd_any(cmd_rd_any), .cmd_wr_over(cmd_wr_over),
        .rd_data(rd_data), .rd_valid(rd_valid), .flt_empty(flt_empty),
        .flt_full(flt_full), .top_ptr(top_ptr), .tag_vec(tag_vec), .cc_word(cc_word)
    );

    int n_chk = 0;
    int n_err = 0;

    logic [DW-1:0] m_regs [8];
    logic [7:0]    m_tags;
    logic [2:0]    m_top;
    logic [3:0]    m_cc;
    logic [DW-1:0] m_rd;
    logic          m_rdv, m_fe, m_ff;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [3:0] c);
        return {1'b0, c[3], 3'b000, c[2], c[1], c[0], 8'h00};
    endfunction

    task automatic compare(input string req);
        chk(top_ptr == m_top, req, "top_ptr", DW'(top_ptr), DW'(m_top));
        chk(tag_vec == m_tags, req, "tag_vec", DW'(tag_vec), DW'(m_tags));
        chk(flt_empty == m_fe, req, "flt_empty", DW'(flt_empty), DW'(m_fe));
        chk(flt_full == m_ff, req, "flt_full", DW'(flt_full), DW'(m_ff));
        chk(rd_valid == m_rdv, req, "rd_valid", DW'(rd_valid), DW'(m_rdv));
        chk(rd_data == m_rd, req, "rd_data", rd_data, m_rd);
        chk(cc_word == exp_word(m_cc), req, "cc_word", DW'(cc_word), DW'(exp_word(m_cc)));
    endtask

    // called on a falling edge; result is compared on the next falling edge
    task automatic cmd(input logic [2:0] op, input logic [2:0] idx,
                       input logic [DW-1:0] d, input bit qa, input bit qw,
                       input string req);
        logic [2:0] ph, dn;
        cmd_op = op; cmd_idx = idx; cmd_data = d;
        cmd_rd_any = qa; cmd_wr_over = qw;
        ph = m_top + idx;
        dn = m_top - 3'd1;
        m_fe = 1'b0; m_ff = 1'b0; m_rdv = 1'b0;
        case (op)
            3'd1: if (m_tags[dn]) m_ff = 1'b1;
                  else begin m_top = dn; m_regs[dn] = d; m_tags[dn] = 1'b1; end
            3'd2: if (!m_tags[m_top]) m_fe = 1'b1;
                  else begin
                      m_rd = m_regs[m_top]; m_rdv = 1'b1;
                      m_tags[m_top] = 1'b0; m_top = m_top + 3'd1;
                  end
            3'd3: if (!m_tags[ph] && !qa) m_fe = 1'b1;
                  else begin m_rd = m_regs[ph]; m_rdv = 1'b1; end
            3'd4: if (m_tags[ph] && !qw) m_ff = 1'b1;
                  else begin m_regs[ph] = d; m_tags[ph] = 1'b1; end
            3'd5: if (!m_tags[ph]) m_fe = 1'b1;
                  else begin m_rd = m_regs[ph]; m_rdv = 1'b1; m_regs[ph] = d; end
            3'd6: m_cc = d[3:0];
            default: ;
        endcase
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #4_000_000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        for (int k = 0; k < 8; k++) m_regs[k] = '0;
        m_tags = '0; m_top = '0; m_cc = '0; m_rd = '0;
        m_rdv = 1'b0; m_fe = 1'b0; m_ff = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        // R2: fill all eight slots, top wraps 0 -> 7 -> ... -> 0
        for (int k = 0; k < 8; k++)
            cmd(3'd1, 3'd0, 64'hA5A5_0000_0000_0000 | DW'(k * 17 + 1), 1'b0, 1'b0, "R2");
        // R2/R8: push onto a full stack faults; R10: write exemption does not help
        cmd(3'd1, 3'd0, 64'hDEAD, 1'b0, 1'b0, "R2");
        cmd(3'd1, 3'd0, 64'hBEEF, 1'b1, 1'b1, "R10");
        // R4: every relative index
        for (int i = 0; i < 8; i++) cmd(3'd3, 3'(i), '0, 1'b0, 1'b0, "R4");
        // R7: modify each slot
        for (int i = 0; i < 8; i++)
            cmd(3'd5, 3'(i), 64'h1234_0000_0000_0000 | DW'(i), 1'b0, 1'b0, "R7");
        // R6/R8: write to occupied faults, exemption allows it
        cmd(3'd4, 3'd5, 64'h5555, 1'b0, 1'b0, "R6");
        cmd(3'd4, 3'd5, 64'h5555, 1'b1, 1'b0, "R10");
        cmd(3'd4, 3'd5, 64'h6666, 1'b0, 1'b1, "R6");
        cmd(3'd3, 3'd5, '0, 1'b0, 1'b0, "R6");
        // R3: drain, then underflow
        for (int k = 0; k < 8; k++) cmd(3'd2, 3'd0, '0, 1'b0, 1'b0, "R3");
        cmd(3'd2, 3'd0, '0, 1'b0, 1'b0, "R3");
        cmd(3'd2, 3'd0, '0, 1'b1, 1'b1, "R10");
        // R5: read of vacant slots with and without exemption
        for (int i = 0; i < 8; i++) begin
            cmd(3'd3, 3'(i), '0, 1'b0, 1'b0, "R5");
            cmd(3'd3, 3'(i), '0, 1'b1, 1'b0, "R5");
        end
        // R7/R10: modify vacant faults even with both qualifiers
        cmd(3'd5, 3'd2, 64'h77, 1'b1, 1'b1, "R7");
        cmd(3'd4, 3'd2, 64'h88, 1'b0, 1'b0, "R6");
        // R9: every condition-code pattern, plus no-op codes
        for (int c = 0; c < 16; c++)
            cmd(3'd6, 3'd0, 64'hFFFF_FFFF_FFFF_FFF0 | DW'(c), 1'b0, 1'b0, "R9");
        cmd(3'd0, 3'd3, 64'hFF, 1'b1, 1'b1, "R9");
        cmd(3'd7, 3'd3, 64'hFF, 1'b1, 1'b1, "R9");
        // mixed stream, all rules against the model
        lfsr = 32'hC0FF_EE01;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cmd(lfsr[2:0], lfsr[5:3], {lfsr, ~lfsr}, lfsr[6], lfsr[7], "R8");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule